// File: doc/BRIEF.md
# Pointer-Addressed RAM Data Port

This block gives a host without memory-mapped access a programmed-I/O path into a byte-addressed on-board RAM. The host loads a write pointer or a read pointer through a small register bus, then streams data through one data port. Each data-port access moves its own pointer forward by the number of bytes it moved, so a buffer is transferred without reloading the pointer between items. Byte and 16-bit word accesses can be mixed freely, which lets a host handle a buffer that starts at an odd offset: one byte, then words, then a trailing byte.

The RAM is built from `BANKS` banks of `BANK_BYTES` bytes each; the full product uses 16 KiB banks and up to four of them. Both pointers wrap modulo the total size, including sizes that are not a power of two. Reads are answered in the same cycle as the read strobe from a two-byte prefetch register. That register follows the read pointer and also snoops RAM writes, so a read always returns the data most recently written.

Top module: `pio_window`

## Requirements
- R1: After reset both the write pointer and the read pointer are zero, as seen by reading register addresses 1 and 2.
- R2: A write with both byte enables (be=2'b11) to address 1 loads the write pointer and to address 2 loads the read pointer. The value taken is the low ceil(log2 size) bits of wdata, less the RAM size once if they reach it. Reading either address returns the pointer zero-extended to 16 bits. A pointer write with a partial byte enable is ignored.
- R3: A data-port write (address 0) with be=2'b01 stores wdata[7:0] at the write pointer and then advances the write pointer by one.
- R4: A data-port write with be=2'b11 stores wdata[7:0] at the write pointer and wdata[15:8] at the next byte, little-endian, and then advances the write pointer by two.
- R5: A data-port read with be=2'b01 returns {8'h00, byte at read pointer} in the same cycle as the strobe, and then advances the read pointer by one.
- R6: A data-port read with be=2'b11 returns {byte at pointer+1, byte at pointer} in the same cycle, and then advances the read pointer by two.
- R7: Pointer advance and the second byte of a word wrap modulo the RAM size, so a word may straddle the last and the first location.
- R8: A stream that starts at an odd offset, written and read as byte, words, byte, lands on consecutive locations and reads back unchanged, and can be reread with word accesses at even alignment.
- R9: Data-port writes never move the read pointer and data-port reads never move the write pointer.
- R10: A read returns bytes written after the read pointer was set, even when they land on the location already prefetched.
- R11: Data-port accesses with be=2'b10 or 2'b00 neither move a pointer nor change RAM, and such a read returns zero. Writes to address 3 have no effect and a read of it returns zero. rd_data is zero whenever rd is low.
- R12: Writing the whole RAM with a word pattern that starts at 1 and rises by 3 per word, then reading it back from location 0, returns the same pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe, ignored while wr is high |
| addr | input | 2 | 0 data port, 1 write pointer, 2 read pointer, 3 unused |
| be | input | 2 | Byte enables: 2'b01 byte access, 2'b11 word access |
| wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid in the cycle of the read strobe |

## Verification
The bench builds the block with three banks of 512 bytes, a 1536-byte RAM that is not a power of two. This puts the modulo wrap of both pointers, a word straddling the end of RAM, and the reduction of an out-of-range pointer value within reach of short tests. It also lets the full fill-and-verify sizing pass cover every location in a few thousand cycles.

// File: rtl/pio_win_pkg.sv
package pio_win_pkg;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_WPTR = 2'd1,
    REG_RPTR = 2'd2,
    REG_RSVD = 2'd3
  } win_reg_e;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_BYTE = 2'd1,
    ACC_WORD = 2'd2
  } acc_e;

  // Access width from the byte enables; the low lane carries single bytes.
  function automatic acc_e acc_kind(input logic [1:0] be);
    case (be)
      2'b01:   return ACC_BYTE;
      2'b11:   return ACC_WORD;
      default: return ACC_NONE;
    endcase
  endfunction

endpackage

// File: rtl/pio_host_decode.sv
module pio_host_decode
  import pio_win_pkg::*;
(
  input  logic       wr,
  input  logic       rd,
  input  logic [1:0] addr,
  input  logic [1:0] be,
  output logic       rd_act,
  output logic       wp_load,
  output logic       rp_load,
  output logic       dwr_en,
  output logic       dwr_word,
  output logic       drd_en,
  output logic       drd_word
);

  acc_e acc;

  always_comb begin
    acc      = acc_kind(be);
    rd_act   = rd && !wr;
    wp_load  = wr && (addr == REG_WPTR) && (be == 2'b11);
    rp_load  = wr && (addr == REG_RPTR) && (be == 2'b11);
    dwr_en   = wr && (addr == REG_DATA) && (acc != ACC_NONE);
    dwr_word = (acc == ACC_WORD);
    drd_en   = rd_act && (addr == REG_DATA) && (acc != ACC_NONE);
    drd_word = (acc == ACC_WORD);
  end

endmodule

// File: rtl/pio_ptr_unit.sv
module pio_ptr_unit #(
  parameter int unsigned SIZE      = 2048,
  parameter int unsigned PTR_W     = 11,
  parameter bit          LOOKAHEAD = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [PTR_W-1:0] load_val,
  input  logic             adv_en,
  input  logic             adv_two,
  output logic [PTR_W-1:0] ptr_o,
  output logic [PTR_W-1:0] pair0_o,
  output logic [PTR_W-1:0] pair1_o
);

  localparam logic [PTR_W:0] SIZE_V = SIZE[PTR_W:0];

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_nxt;
  logic             ptr_en;

  function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] a,
                                                input logic [1:0] s);
    logic [PTR_W:0] t;
    t = {1'b0, a} + {{(PTR_W-1){1'b0}}, s};
    if (t >= SIZE_V) t = t - SIZE_V;
    return t[PTR_W-1:0];
  endfunction

  function automatic logic [PTR_W-1:0] reduce(input logic [PTR_W-1:0] v);
    logic [PTR_W:0] t;
    t = {1'b0, v};
    if (t >= SIZE_V) t = t - SIZE_V;
    return t[PTR_W-1:0];
  endfunction

  // next-state
  always_comb begin
    ptr_en  = load_en || adv_en;
    ptr_nxt = ptr_q;
    if (load_en)     ptr_nxt = reduce(load_val);
    else if (adv_en) ptr_nxt = wrap_add(ptr_q, adv_two ? 2'd2 : 2'd1);
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_nxt;
  end

  assign ptr_o = ptr_q;

  // The address pair is either the current location (write side) or the
  // location after this cycle's update (read prefetch side).
  generate
    if (LOOKAHEAD) begin : g_ahead
      assign pair0_o = ptr_nxt;
      assign pair1_o = wrap_add(ptr_nxt, 2'd1);
    end else begin : g_now
      assign pair0_o = ptr_q;
      assign pair1_o = wrap_add(ptr_q, 2'd1);
    end
  endgenerate

endmodule

// File: rtl/pio_byte_ram.sv
module pio_byte_ram #(
  parameter int unsigned SIZE  = 2048,
  parameter int unsigned PTR_W = 11
) (
  input  logic             clk,
  input  logic             we0,
  input  logic [PTR_W-1:0] wa0,
  input  logic [7:0]       wd0,
  input  logic             we1,
  input  logic [PTR_W-1:0] wa1,
  input  logic [7:0]       wd1,
  input  logic [PTR_W-1:0] ra0,
  input  logic [PTR_W-1:0] ra1,
  output logic [7:0]       rq0,
  output logic [7:0]       rq1
);

  logic [7:0] mem [SIZE];

  always_ff @(posedge clk) begin
    if (we0) mem[wa0] <= wd0;
    if (we1) mem[wa1] <= wd1;
  end

  assign rq0 = mem[ra0];
  assign rq1 = mem[ra1];

endmodule

// File: rtl/pio_prefetch.sv
module pio_prefetch #(
  parameter int unsigned PTR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [PTR_W-1:0] la0,
  input  logic [PTR_W-1:0] la1,
  input  logic [7:0]       ram_q0,
  input  logic [7:0]       ram_q1,
  input  logic             we0,
  input  logic [PTR_W-1:0] wa0,
  input  logic [7:0]       wd0,
  input  logic             we1,
  input  logic [PTR_W-1:0] wa1,
  input  logic [7:0]       wd1,
  output logic [1:0][7:0]  pf_o
);

  logic [1:0]            hit_v;
  logic                  load_en;
  logic [1:0][PTR_W-1:0] lane_a;
  logic [1:0][7:0]       lane_ram;

  assign lane_a   = {la1, la0};
  assign lane_ram = {ram_q1, ram_q0};
  assign load_en  = reload || (hit_v != 2'b00);

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      logic       hit0, hit1;
      logic [7:0] byte_n, byte_q;

      // next-state: a write landing on this lane's address bypasses the RAM
      always_comb begin
        hit0   = we0 && (wa0 == lane_a[g]);
        hit1   = we1 && (wa1 == lane_a[g]);
        byte_n = lane_ram[g];
        if (hit1)      byte_n = wd1;
        else if (hit0) byte_n = wd0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= '0;
        else if (load_en) byte_q <= byte_n;
      end

      assign hit_v[g] = hit0 || hit1;
      assign pf_o[g]  = byte_q;
    end
  endgenerate

endmodule

// File: rtl/pio_window.sv
module pio_window
  import pio_win_pkg::*;
#(
  parameter int unsigned BANK_BYTES = 1024,
  parameter int unsigned BANKS      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic        rd,
  input  logic [1:0]  addr,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] rd_data
);

  localparam int unsigned SIZE  = BANK_BYTES * BANKS;
  localparam int unsigned PTR_W = $clog2(SIZE);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             rd_act, wp_load, rp_load;
  logic             dwr_en, dwr_word, drd_en, drd_word;
  logic [PTR_W-1:0] wptr_q, wa0, wa1;
  logic [PTR_W-1:0] rptr_q, ra0, ra1;
  logic [7:0]       rq0, rq1;
  logic             we1;
  logic [1:0][7:0]  pf;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pio_host_decode u_dec (
    .wr       (wr),
    .rd       (rd),
    .addr     (addr),
    .be       (be),
    .rd_act   (rd_act),
    .wp_load  (wp_load),
    .rp_load  (rp_load),
    .dwr_en   (dwr_en),
    .dwr_word (dwr_word),
    .drd_en   (drd_en),
    .drd_word (drd_word)
  );

  pio_ptr_unit #(.SIZE(SIZE), .PTR_W(PTR_W), .LOOKAHEAD(1'b0)) u_wptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (wp_load),
    .load_val (wdata[PTR_W-1:0]),
    .adv_en   (dwr_en),
    .adv_two  (dwr_word),
    .ptr_o    (wptr_q),
    .pair0_o  (wa0),
    .pair1_o  (wa1)
  );

  pio_ptr_unit #(.SIZE(SIZE), .PTR_W(PTR_W), .LOOKAHEAD(1'b1)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load_en  (rp_load),
    .load_val (wdata[PTR_W-1:0]),
    .adv_en   (drd_en),
    .adv_two  (drd_word),
    .ptr_o    (rptr_q),
    .pair0_o  (ra0),
    .pair1_o  (ra1)
  );

  assign we1 = dwr_en && dwr_word;

  pio_byte_ram #(.SIZE(SIZE), .PTR_W(PTR_W)) u_ram (
    .clk (clk),
    .we0 (dwr_en),
    .wa0 (wa0),
    .wd0 (wdata[7:0]),
    .we1 (we1),
    .wa1 (wa1),
    .wd1 (wdata[15:8]),
    .ra0 (ra0),
    .ra1 (ra1),
    .rq0 (rq0),
    .rq1 (rq1)
  );

  pio_prefetch #(.PTR_W(PTR_W)) u_pf (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .reload (rp_load || drd_en),
    .la0    (ra0),
    .la1    (ra1),
    .ram_q0 (rq0),
    .ram_q1 (rq1),
    .we0    (dwr_en),
    .wa0    (wa0),
    .wd0    (wdata[7:0]),
    .we1    (we1),
    .wa1    (wa1),
    .wd1    (wdata[15:8]),
    .pf_o   (pf)
  );

  // read return path, answered in the strobe cycle
  always_comb begin
    rd_data = '0;
    if (rd_act) begin
      case (addr)
        REG_DATA: if (drd_en) rd_data = drd_word ? {pf[1], pf[0]} : {8'h00, pf[0]};
        REG_WPTR: rd_data = 16'(wptr_q);
        REG_RPTR: rd_data = 16'(rptr_q);
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/pio_window_chk.sv
module pio_window_chk #(
  parameter int unsigned SIZE  = 2048,
  parameter int unsigned PTR_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic             rd,
  input logic [1:0]       addr,
  input logic [1:0]       be,
  input logic [15:0]      wdata,
  input logic [15:0]      rd_data,
  input logic [PTR_W-1:0] wptr_q,
  input logic [PTR_W-1:0] rptr_q
);

  logic [31:0] wptr_i, rptr_i, wval_i;
  logic        rd_dp;

  assign wptr_i = 32'(wptr_q);
  assign rptr_i = 32'(rptr_q);
  assign wval_i = 32'(wdata[PTR_W-1:0]);
  assign rd_dp  = rd && !wr && (addr == 2'd0);

  assert_wptr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd1 && be == 2'b11 && wval_i < SIZE) |=> wptr_i == $past(wval_i));

  assert_wptr_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && be == 2'b01) |=> wptr_i == ($past(wptr_i) + 1) % SIZE);

  assert_wptr_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && be == 2'b11) |=> wptr_i == ($past(wptr_i) + 2) % SIZE);

  assert_rptr_byte_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dp && be == 2'b01) |=> rptr_i == ($past(rptr_i) + 1) % SIZE);

  assert_rptr_word_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dp && be == 2'b11) |=> rptr_i == ($past(rptr_i) + 2) % SIZE);

  assert_byte_read_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_dp && be == 2'b01) |-> rd_data[15:8] == 8'h00);

  assert_ptr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_i < SIZE) && (rptr_i < SIZE));

  assert_rptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_dp && !(wr && addr == 2'd2)) |=> $stable(rptr_q));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |-> rd_data == 16'h0000);

endmodule

bind pio_window pio_window_chk #(.SIZE(SIZE), .PTR_W(PTR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .wr      (wr),
  .rd      (rd),
  .addr    (addr),
  .be      (be),
  .wdata   (wdata),
  .rd_data (rd_data),
  .wptr_q  (wptr_q),
  .rptr_q  (rptr_q)
);

// File: tb/test_pio_window.sv
module test_pio_window;

  localparam int CLK_PERIOD = 10;
  localparam int BANK_BYTES = 512;
  localparam int BANKS      = 3;
  localparam int SIZE       = BANK_BYTES * BANKS;
  localparam int PTR_W      = $clog2(SIZE);

  logic        clk, rst_n, wr, rd;
  logic [1:0]  addr, be;
  logic [15:0] wdata, rd_data;

  pio_window #(.BANK_BYTES(BANK_BYTES), .BANKS(BANKS)) i_pio_window (
    .clk(clk), .rst_n(rst_n), .wr(wr), .rd(rd), .addr(addr), .be(be),
    .wdata(wdata), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  mem_m [SIZE];
  int          wp_m, rp_m;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  int          checks, fails;
  bit          done;

  function automatic int reduce(input int v);
    int t;
    t = v & ((1 << PTR_W) - 1);
    if (t >= SIZE) t = t - SIZE;
    return t;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic r, input logic [1:0] a,
                       input logic [1:0] b, input logic [15:0] d);
    @(posedge clk); #1;
    wr = w; rd = r; addr = a; be = b; wdata = d;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr = 1'b0; rd = 1'b0; addr = 2'd0; be = 2'b00; wdata = '0;
  endtask

  // driver: bus write, model updated alongside
  task automatic bwr(input logic [1:0] a, input logic [1:0] b, input logic [15:0] d);
    drive(1'b1, 1'b0, a, b, d);
    if (a == 2'd1 && b == 2'b11) wp_m = reduce(int'(d));
    else if (a == 2'd2 && b == 2'b11) rp_m = reduce(int'(d));
    else if (a == 2'd0 && b == 2'b01) begin
      mem_m[wp_m] = d[7:0]; wp_m = (wp_m + 1) % SIZE;
    end else if (a == 2'd0 && b == 2'b11) begin
      mem_m[wp_m] = d[7:0]; mem_m[(wp_m + 1) % SIZE] = d[15:8];
      wp_m = (wp_m + 2) % SIZE;
    end
  endtask

  // driver: bus read, expected value pushed to the scoreboard
  task automatic brd(input logic [1:0] a, input logic [1:0] b, input string tag);
    logic [15:0] e;
    e = '0;
    if (a == 2'd1) e = 16'(wp_m);
    else if (a == 2'd2) e = 16'(rp_m);
    else if (a == 2'd0 && b == 2'b01) begin
      e = {8'h00, mem_m[rp_m]}; rp_m = (rp_m + 1) % SIZE;
    end else if (a == 2'd0 && b == 2'b11) begin
      e = {mem_m[(rp_m + 1) % SIZE], mem_m[rp_m]}; rp_m = (rp_m + 2) % SIZE;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    drive(1'b0, 1'b1, a, b, 16'h0);
  endtask

  // monitor: compares each read in its strobe cycle, away from the edge
  always @(negedge clk) begin
    if (!done && rst_n && rd) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11 unexpected read actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0; wp_m = 0; rp_m = 0;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = 2'd0; be = 2'b00; wdata = '0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    brd(2'd1, 2'b11, "R1 wptr after reset");
    brd(2'd2, 2'b11, "R1 rptr after reset");

    // R3 / R4 writes, R5 / R6 reads
    bwr(2'd1, 2'b11, 16'h0010);
    bwr(2'd0, 2'b11, 16'hBEEF);
    bwr(2'd0, 2'b01, 16'h005A);
    brd(2'd1, 2'b11, "R3 R4 wptr advance");
    bwr(2'd2, 2'b11, 16'h0010);
    brd(2'd0, 2'b01, "R5 byte read");
    brd(2'd0, 2'b11, "R6 word read");
    brd(2'd2, 2'b11, "R6 rptr advance");

    // R2 pointer reduction and partial enable
    bwr(2'd2, 2'b11, 16'h0700);
    brd(2'd2, 2'b11, "R2 rptr reduced");
    bwr(2'd2, 2'b11, 16'hF805);
    brd(2'd2, 2'b11, "R2 rptr low bits");
    drive(1'b1, 1'b0, 2'd2, 2'b01, 16'h0033);
    brd(2'd2, 2'b11, "R2 partial write ignored");

    // R8 odd-offset stream
    bwr(2'd1, 2'b11, 16'h0021);
    bwr(2'd0, 2'b01, 16'h0011);
    bwr(2'd0, 2'b11, 16'h3322);
    bwr(2'd0, 2'b11, 16'h5544);
    bwr(2'd0, 2'b01, 16'h0066);
    bwr(2'd2, 2'b11, 16'h0021);
    brd(2'd0, 2'b01, "R8 lead byte");
    brd(2'd0, 2'b11, "R8 word 1");
    brd(2'd0, 2'b11, "R8 word 2");
    brd(2'd0, 2'b01, "R8 tail byte");
    bwr(2'd2, 2'b11, 16'h0022);
    brd(2'd0, 2'b11, "R8 even realign");

    // R7 wrap
    bwr(2'd1, 2'b11, 16'(SIZE - 1));
    bwr(2'd0, 2'b11, 16'hA1B2);
    brd(2'd1, 2'b11, "R7 wptr wrap");
    bwr(2'd2, 2'b11, 16'(SIZE - 1));
    brd(2'd0, 2'b11, "R7 straddling word");
    brd(2'd2, 2'b11, "R7 rptr wrap");

    // R9 independence
    bwr(2'd2, 2'b11, 16'h0021);
    bwr(2'd1, 2'b11, 16'h0100);
    bwr(2'd0, 2'b11, 16'h0102);
    bwr(2'd0, 2'b11, 16'h0304);
    brd(2'd2, 2'b11, "R9 rptr unmoved by writes");
    brd(2'd0, 2'b01, "R9 read after writes");
    brd(2'd1, 2'b11, "R9 wptr unmoved by reads");

    // R10 coherence with the prefetch
    bwr(2'd2, 2'b11, 16'h0200);
    bwr(2'd1, 2'b11, 16'h0200);
    bwr(2'd0, 2'b11, 16'h1234);
    brd(2'd0, 2'b11, "R10 prefetched word");
    bwr(2'd2, 2'b11, 16'h0301);
    bwr(2'd1, 2'b11, 16'h0300);
    bwr(2'd0, 2'b11, 16'hCAFE);
    brd(2'd0, 2'b01, "R10 prefetched high byte");

    // R11 ignored accesses
    bwr(2'd1, 2'b11, 16'h0040);
    bwr(2'd0, 2'b01, 16'h0077);
    bwr(2'd1, 2'b11, 16'h0040);
    drive(1'b1, 1'b0, 2'd0, 2'b10, 16'h9900);
    drive(1'b1, 1'b0, 2'd0, 2'b00, 16'h8800);
    drive(1'b1, 1'b0, 2'd3, 2'b11, 16'h0005);
    brd(2'd1, 2'b11, "R11 wptr not moved");
    bwr(2'd2, 2'b11, 16'h0040);
    brd(2'd0, 2'b10, "R11 upper-lane read zero");
    brd(2'd0, 2'b00, "R11 no-lane read zero");
    brd(2'd2, 2'b11, "R11 rptr not moved");
    brd(2'd0, 2'b01, "R11 byte unchanged");
    brd(2'd3, 2'b11, "R11 unused address");
    brd(2'd1, 2'b11, "R11 address 3 write no effect");
    idle();
    @(negedge clk);
    check("R11 idle rd_data", rd_data, 16'h0000);

    // R12 sizing pattern over the whole RAM
    bwr(2'd1, 2'b11, 16'h0000);
    for (int i = 0; i < SIZE / 2; i++) bwr(2'd0, 2'b11, 16'(1 + 3 * i));
    bwr(2'd2, 2'b11, 16'h0000);
    for (int i = 0; i < SIZE / 2; i++) begin
      if (16'(1 + 3 * i) != {mem_m[(2 * i + 1) % SIZE], mem_m[2 * i]}) begin
        checks++; fails++;
        $display("FAIL R12 model pattern actual=%h expected=%h",
                 {mem_m[(2 * i + 1) % SIZE], mem_m[2 * i]}, 16'(1 + 3 * i));
      end
      brd(2'd0, 2'b11, "R12 sizing pattern");
    end
    brd(2'd1, 2'b11, "R12 wptr back at zero");

    idle();
    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R12 pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

endmodule